// File: doc/BRIEF.md
# Configuration Image Bit Serializer

This block streams a stored device configuration image to a configuration port. It reads the image a byte at a time from a byte-wide memory, issuing an incrementing address with a read request and waiting for a read-valid answer. In serial mode each byte leaves as eight consecutive bits with a data-valid strobe. In byte-wide mode each byte leaves whole, with a one-cycle strobe.

A static order input tells the block whether the stored image holds every byte bit-reversed or in native order. In serial mode this input picks the shift direction, so the device always receives each original byte most significant bit first. In byte-wide mode the stored byte goes through unchanged, because a reversed image is already laid out for a bit-for-bit byte-wide connection. The block also watches its own serial output for the 32-bit synchronization pattern that follows the all-ones dummy words, and it raises a sticky flag when it finds that pattern.

Top module: `cfg_stream_serializer`

## Requirements
- R1: After reset mem_rd, ser_valid, par_valid, busy, done and sync_found are all low.
- R2: A transfer issues exactly byte_count reads. Addresses run upward from 0 by one per read, and mem_rd and mem_addr stay steady until mem_valid answers.
- R3: With order_rev=0 in serial mode, each stored byte is sent on ser_bit with bit 7 first and bit 0 last, and bytes go in address order.
- R4: With order_rev=1 in serial mode, each stored byte is sent with bit 0 first and bit 7 last.
- R5: With wide_mode=1, every stored byte appears on par_data bit for bit (stored bit k on output bit k) with one par_valid pulse per byte, whatever order_rev is. ser_valid stays low.
- R6: In serial mode ser_valid is high for exactly 8 cycles per byte. When memory answers within 6 cycles of a request, the high cycles form one unbroken run from the first bit to the last.
- R7: sync_found rises once the last 32 serial bits, first-sent bit as MSB, equal 0xAA995566. It then stays high until reset or an accepted start.
- R8: done rises after the last byte has left and holds until the next accepted start. busy is low while done is high. A byte_count of 0 gives done with no read.
- R9: wide_mode and order_rev are captured when start is accepted. Changes to them during a transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer; accepted only while idle |
| byte_count | input | ADDR_W+1 | Number of image bytes to send |
| wide_mode | input | 1 | 1: byte-wide output, 0: serial output |
| order_rev | input | 1 | 1: stored bytes are bit-reversed |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rd | output | 1 | Read request, held until answered |
| mem_rdata | input | 8 | Read data |
| mem_valid | input | 1 | Read data valid |
| ser_bit | output | 1 | Serial configuration data |
| ser_valid | output | 1 | Serial bit valid |
| par_data | output | 8 | Byte-wide configuration data |
| par_valid | output | 1 | Byte valid |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| sync_found | output | 1 | Sync pattern seen in the serial stream |

## Verification
The stimulus includes a native image and a reversed image that carry the full sync word. Both must raise the flag, which shows that the shift direction follows the order input. A reversed image sent with the order flag cleared must not raise the flag. It puts 0x55 and 0xAA in each other's places, a difference that the symmetric bytes 0x99 and 0x66 alone could never show. A native image with only symmetric bytes also tests the detector. Byte-wide runs, with both settings of the order flag, show that the flag does not touch parallel data. A truncated count, a zero count and a mid-transfer change of the mode inputs test the boundaries.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

  localparam logic [31:0] SYNC_PATTERN = 32'hAA995566;

  function automatic logic [7:0] flip8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  typedef enum logic {XF_IDLE = 1'b0, XF_RUN = 1'b1} xfer_state_t;

endpackage

// File: rtl/cfgser_fetch.sv
module cfgser_fetch #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              active,
  input  logic [CNT_W-1:0]  count,
  input  logic              take,
  input  logic              mem_valid,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic [7:0]        hold_data,
  output logic              hold_full,
  output logic              all_fetched
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  got_q, got_d, lim_q, lim_d;
  logic              req_q, req_d;
  logic [7:0]        buf_q, buf_d;
  logic              full_q, full_d;
  logic              fill;

  assign fill = req_q && mem_valid;

  always_comb begin
    addr_d = addr_q;
    got_d  = got_q;
    lim_d  = lim_q;
    req_d  = req_q;
    buf_d  = buf_q;
    full_d = full_q;
    if (go) begin
      addr_d = '0;
      got_d  = '0;
      lim_d  = count;
      req_d  = 1'b0;
      full_d = 1'b0;
    end else begin
      if (take) full_d = 1'b0;
      if (fill) begin
        buf_d  = mem_rdata;
        full_d = 1'b1;
        req_d  = 1'b0;
        addr_d = addr_q + 1'b1;
        got_d  = got_q + 1'b1;
      end else if (active && !full_q && !req_q && (got_q != lim_q)) begin
        req_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      got_q  <= '0;
      lim_q  <= '0;
      req_q  <= 1'b0;
      buf_q  <= '0;
      full_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      got_q  <= got_d;
      lim_q  <= lim_d;
      req_q  <= req_d;
      buf_q  <= buf_d;
      full_q <= full_d;
    end
  end

  assign mem_addr    = addr_q;
  assign mem_rd      = req_q;
  assign hold_data   = buf_q;
  assign hold_full   = full_q;
  assign all_fetched = (got_q == lim_q) && !req_q;

endmodule

// File: rtl/cfgser_shift.sv
module cfgser_shift
  import cfgser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       active,
  input  logic       wide,
  input  logic       rev,
  input  logic       hold_full,
  input  logic [7:0] hold_data,
  output logic       take,
  output logic       ser_bit,
  output logic       ser_valid,
  output logic [7:0] par_data,
  output logic       par_valid,
  output logic       shifting
);

  logic [7:0] sh_q, sh_d;
  logic [2:0] pos_q, pos_d;
  logic       act_q, act_d;
  logic [7:0] pd_q, pd_d;
  logic       pv_q, pv_d;
  logic       last_bit;

  assign last_bit = act_q && (pos_q == 3'd7);
  assign take = active && hold_full && (wide || !act_q || last_bit);

  always_comb begin
    sh_d  = sh_q;
    pos_d = pos_q;
    act_d = act_q;
    pd_d  = pd_q;
    pv_d  = 1'b0;
    if (clr) begin
      act_d = 1'b0;
      pos_d = '0;
    end else if (take && wide) begin
      pd_d = hold_data;
      pv_d = 1'b1;
    end else if (take) begin
      sh_d  = rev ? flip8(hold_data) : hold_data;
      pos_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      sh_d  = {sh_q[6:0], 1'b0};
      pos_d = pos_q + 1'b1;
      if (last_bit) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      pos_q <= '0;
      act_q <= 1'b0;
      pd_q  <= '0;
      pv_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      pos_q <= pos_d;
      act_q <= act_d;
      pd_q  <= pd_d;
      pv_q  <= pv_d;
    end
  end

  assign ser_bit   = act_q ? sh_q[7] : 1'b0;
  assign ser_valid = act_q;
  assign par_data  = pd_q;
  assign par_valid = pv_q;
  assign shifting  = act_q;

endmodule

// File: rtl/cfgser_sync_watch.sv
module cfgser_sync_watch
  import cfgser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_in,
  input  logic bit_vld,
  output logic found
);

  logic [31:0] win_q, win_d;
  logic        hit_q, hit_d;

  always_comb begin
    win_d = win_q;
    hit_d = hit_q;
    if (clr) begin
      win_d = '0;
      hit_d = 1'b0;
    end else if (bit_vld) begin
      win_d = {win_q[30:0], bit_in};
      if (win_d == SYNC_PATTERN) hit_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      hit_q <= 1'b0;
    end else begin
      win_q <= win_d;
      hit_q <= hit_d;
    end
  end

  assign found = hit_q;

endmodule

// File: rtl/cfg_stream_serializer.sv
module cfg_stream_serializer
  import cfgser_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              wide_mode,
  input  logic              order_rev,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_valid,
  output logic              ser_bit,
  output logic              ser_valid,
  output logic [7:0]        par_data,
  output logic              par_valid,
  output logic              busy,
  output logic              done,
  output logic              sync_found
);

  xfer_state_t st_q, st_d;
  logic        wide_q, wide_d, rev_q, rev_d, done_q, done_d;
  logic        go, running, finish;
  logic [7:0]  hold_data;
  logic        hold_full, all_fetched, take, shifting;

  assign go      = start && (st_q == XF_IDLE);
  assign running = (st_q == XF_RUN);
  assign finish  = running && all_fetched && !hold_full && !shifting;

  always_comb begin
    st_d   = st_q;
    wide_d = wide_q;
    rev_d  = rev_q;
    done_d = done_q;
    if (go) begin
      st_d   = XF_RUN;
      wide_d = wide_mode;
      rev_d  = order_rev;
      done_d = 1'b0;
    end else if (finish) begin
      st_d   = XF_IDLE;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XF_IDLE;
      wide_q <= 1'b0;
      rev_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wide_q <= wide_d;
      rev_q  <= rev_d;
      done_q <= done_d;
    end
  end

  cfgser_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) fetch_i (
    .clk(clk), .rst_n(rst_n), .go(go), .active(running), .count(byte_count),
    .take(take), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .hold_data(hold_data),
    .hold_full(hold_full), .all_fetched(all_fetched)
  );

  cfgser_shift shift_i (
    .clk(clk), .rst_n(rst_n), .clr(go), .active(running), .wide(wide_q),
    .rev(rev_q), .hold_full(hold_full), .hold_data(hold_data), .take(take),
    .ser_bit(ser_bit), .ser_valid(ser_valid), .par_data(par_data),
    .par_valid(par_valid), .shifting(shifting)
  );

  cfgser_sync_watch watch_i (
    .clk(clk), .rst_n(rst_n), .clr(go), .bit_in(ser_bit),
    .bit_vld(ser_valid), .found(sync_found)
  );

  assign busy = running;
  assign done = done_q;

endmodule

// File: rtl/cfg_stream_serializer_chk.sv
module cfg_stream_serializer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ser_valid,
  input logic              par_valid,
  input logic              sync_found
);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_valid |=> mem_rd && $stable(mem_addr));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_valid |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  // R5
  lane_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_valid && ser_valid));

  // R7
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found && !(start && !busy) |=> sync_found);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);

endmodule

bind cfg_stream_serializer cfg_stream_serializer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_rd(mem_rd), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .ser_valid(ser_valid), .par_valid(par_valid), .sync_found(sync_found)
);

// File: tb/cfg_stream_serializer_tb.sv
`timescale 1ns/1ps
module cfg_stream_serializer_tb_top;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = ADDR_W + 1;
  localparam int NV     = 6;

  // image (first byte in the top bits), order flag, wide flag, expected sync
  localparam logic [63:0] V_IMG [NV] = '{
    64'hFFFFFFFF_AA995566,   // native image with sync
    64'hFFFFFFFF_5599AA66,   // reversed image with sync
    64'hFFFFFFFF_5599AA66,   // reversed image sent as native: no sync
    64'hFFFFFFFF_99996666,   // symmetric bytes only: no sync
    64'hFFFFFFFF_AA995566,   // byte-wide, native
    64'h0123_4567_89AB_CDEF  // byte-wide, reversed flag
  };
  localparam logic V_REV  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic V_WIDE [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic V_SYNC [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic wide_mode = 1'b0, order_rev = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rd;
  logic [7:0] mem_rdata = '0;
  logic mem_valid = 1'b0;
  logic ser_bit, ser_valid, par_valid, busy, done, sync_found;
  logic [7:0] par_data;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] mem [16];
  int rd_count = 0, addr_err = 0;
  logic rd_clr = 1'b0;

  always #2.5 clk = ~clk;

  cfg_stream_serializer #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .wide_mode(wide_mode), .order_rev(order_rev), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .ser_bit(ser_bit), .ser_valid(ser_valid), .par_data(par_data),
    .par_valid(par_valid), .busy(busy), .done(done), .sync_found(sync_found)
  );

  // memory model: answers one cycle after a request, away from the edge
  always @(negedge clk) begin
    cycles++;
    if (rd_clr) begin
      rd_count = 0;
      addr_err = 0;
    end
    if (mem_rd && !mem_valid) begin
      mem_valid = 1'b1;
      mem_rdata = mem[mem_addr[3:0]];
      if (int'(mem_addr) != rd_count) addr_err++;
      rd_count++;
    end else begin
      mem_valid = 1'b0;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one transfer; toggle_at>0 flips the mode inputs after that many cycles
  task automatic run_xfer(input logic [63:0] img, input int n, input logic rev,
                          input logic wide, input logic exp_sync, input int toggle_at);
    logic [7:0] b [8];
    int nbits = 0, nbytes = 0, first = -1, last = -1, badbit = 0, badbyte = 0, t = 0;
    for (int i = 0; i < 8; i++) begin
      b[i] = img[63-8*i -: 8];
      mem[i] = b[i];
    end
    @(negedge clk);
    rd_clr = 1'b1;
    byte_count = CNT_W'(n);
    order_rev = rev;
    wide_mode = wide;
    start = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
    start = 1'b0;
    chk(sync_found == 1'b0 && done == 1'b0 && busy == 1'b1, "R7 clear on start", {sync_found, done, busy}, 3'b001);
    while (!done && t < 2000) begin
      if (ser_valid) begin
        int k = nbits;
        logic e = rev ? b[k/8][k%8] : b[k/8][7-(k%8)];
        if (ser_bit != e) badbit++;
        if (first < 0) first = t;
        last = t;
        nbits++;
      end
      if (par_valid) begin
        if (par_data != b[nbytes]) badbyte++;
        nbytes++;
      end
      if (toggle_at > 0 && t == toggle_at) begin
        order_rev = ~rev;
        wide_mode = ~wide;
      end
      t++;
      @(negedge clk);
    end
    order_rev = rev;
    wide_mode = wide;
    chk(done == 1'b1 && busy == 1'b0, "R8 done", {done, busy}, 2'b10);
    chk(rd_count == n && addr_err == 0, "R2 reads", rd_count, n);
    if (wide) begin
      chk(nbytes == n && badbyte == 0, "R5 byte path", badbyte, 0);
      chk(nbits == 0, "R5 serial idle", nbits, 0);
    end else begin
      chk(badbit == 0, rev ? "R4 lsb first" : "R3 msb first", badbit, 0);
      chk(nbits == 8*n && (n == 0 || last - first + 1 == nbits), "R6 gapless",
          last - first + 1, 8*n);
    end
    chk(sync_found == exp_sync, "R7 sync flag", sync_found, exp_sync);
    @(negedge clk);
    chk(done == 1'b1 && sync_found == exp_sync, "R8/R7 hold", {done, sync_found}, {1'b1, exp_sync});
  endtask

  initial begin
    #1;
    chk(mem_rd == 0 && ser_valid == 0 && par_valid == 0 && busy == 0 && done == 0 && sync_found == 0,
        "R1 reset", {mem_rd, ser_valid, par_valid, busy, done, sync_found}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && sync_found == 0, "R1 after release", {busy, done, sync_found}, 0);

    for (int v = 0; v < NV; v++)
      run_xfer(V_IMG[v], 8, V_REV[v], V_WIDE[v], V_SYNC[v], 0);

    // truncated count: sync word cut short (R7)
    run_xfer(V_IMG[0], 7, 1'b0, 1'b0, 1'b0, 0);
    // zero count: done with no reads (R8)
    run_xfer(V_IMG[0], 0, 1'b0, 1'b0, 1'b0, 0);
    // mode inputs flipped mid-transfer must not matter (R9)
    run_xfer(V_IMG[1], 8, 1'b1, 1'b0, 1'b1, 12);
    run_xfer(V_IMG[5], 8, 1'b0, 1'b1, 1'b0, 5);

    // reset clears a set sync flag (R1, R7)
    run_xfer(V_IMG[0], 8, 1'b0, 1'b0, 1'b1, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(sync_found == 0 && done == 0, "R7 reset clears flag", {sync_found, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule